// File: doc/BRIEF.md
# Multichannel PCM Wavetable Voice Mixer

The mixer plays back up to eight wavetable voices and combines them into one stereo sample on each output sample period. A strobe starts a sweep over the channels. For each channel that is switched on, the sweep reads one 8-bit byte from a 64K-byte wave memory at the address held in the channel's fixed-point pointer, then advances the pointer by the channel's step. A byte of 0xFF marks the end of a waveform. It sends the pointer back to the channel's loop address and causes a refetch from there.

Samples are stored in sign-magnitude form. Each decoded sample is scaled by an 8-bit envelope and by a 4-bit pan gain for each side. The scaled values are summed, and each side is saturated to 16 bits. The channels share one memory read port and one multiply path, and they are processed one after another. A valid pulse marks the finished stereo pair. The memory is external and returns data one cycle after the address is presented. The channel settings come in as static vectors.

Top module: `pcm_voice_mixer`

## Requirements
- R1: A channel takes part in a sweep only when its bit in `chan_on_i` is 1. While that bit is 0, the channel's pointer is held at the byte address `start_i*256`: the start byte sits in pointer bits [26:19], and all lower bits are zero. Playback begins there once the channel is switched on.
- R2: The pointer is 27 bits wide, with 11 fractional bits. The wave memory byte address is pointer bits [26:11]. After each fetch that is not a marker, the pointer grows by the 16-bit `step_i` of that channel.
- R3: A fetched byte of 0xFF sets the pointer to `loop_i` shifted left by 11, with no step added. The byte at byte address `loop_i` is then fetched and used in its place.
- R4: If the refetched byte at the loop address is also 0xFF, the channel adds zero to both sides for that sample.
- R5: A sample byte with bit 7 set is positive, with magnitude bits [6:0]. With bit 7 clear it is negative, with the same magnitude.
- R6: The left term is (signed sample × envelope × `pan_i[3:0]`) arithmetically shifted right by 5, which rounds toward minus infinity. The right term uses `pan_i[7:4]`. The terms of all active channels are summed as signed values.
- R7: Each side's sum is saturated to the range −32768..32767.
- R8: While `mix_en_i` is 0, both outputs read 0 from the next cycle on, strobes start no sweep, `valid_o` stays low, and the pointers of active channels do not move.
- R9: Each accepted strobe produces exactly one single-cycle `valid_o` pulse, which comes with the new outputs. A strobe that arrives while a sweep is running is ignored.
- R10: Pointer overflow wraps modulo 2^27 without any other effect.
- R11: After reset, both outputs are 0 and `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_tick_i | input | 1 | Starts one mixing sweep |
| mix_en_i | input | 1 | Global enable; low forces silence |
| chan_on_i | input | 8 | Per-channel active mask |
| env_i | input | 8x8 | Per-channel envelope gain |
| pan_i | input | 8x8 | Per-channel pan: [3:0] left, [7:4] right |
| step_i | input | 8x16 | Per-channel pointer increment (5.11) |
| loop_i | input | 8x16 | Per-channel loop byte address |
| start_i | input | 8x8 | Per-channel start page (byte address /256) |
| mem_addr_o | output | 16 | Wave memory byte address |
| mem_rdata_i | input | 8 | Wave memory data, one cycle after the address |
| left_o | output | 16 | Left mixed sample, signed |
| right_o | output | 16 | Right mixed sample, signed |
| valid_o | output | 1 | One-cycle pulse with each new sample pair |

## Verification
The hardest case to reach is a loop whose target is itself a marker. The pointer has to reach an end marker by normal stepping, and the loop address has to point at a second 0xFF. The bench places a short waveform whose second byte is a marker and whose loop address points to another marker. It then runs enough sweeps to see one audible sample followed by permanent silence. Pointer wrap is reached in a similar way: the bench sets a start page near the top of memory and a near-maximum step, so that a handful of sweeps carries the pointer past 2^27.

// File: rtl/pcm_mix_pkg.sv
package pcm_mix_pkg;
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_LOOP, S_DONE} seq_state_e;
  localparam logic [7:0] END_MARK = 8'hFF;
endpackage

// File: rtl/pcm_mix_seq.sv
module pcm_mix_seq
  import pcm_mix_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           en_i,
  input  logic [NCH-1:0] chan_on_i,
  input  logic [7:0]     rdata_i,
  input  logic [AW-1:0]  cur_addr_i,
  input  logic [AW-1:0]  cur_loop_i,
  output logic [CW-1:0]  ch_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic           adv_o,
  output logic           reload_o,
  output logic           lat_o,
  output logic           start_o,
  output logic           done_o
);
  seq_state_e state_q, state_d;
  logic [CW-1:0] ch_q, ch_d;
  logic last;

  assign last   = (ch_q == CW'(NCH - 1));
  assign ch_o   = ch_q;
  assign done_o = (state_q == S_DONE);

  always_comb begin
    state_d    = state_q;
    ch_d       = ch_q;
    adv_o      = 1'b0;
    reload_o   = 1'b0;
    lat_o      = 1'b0;
    start_o    = 1'b0;
    mem_addr_o = cur_addr_i;
    if (!en_i) begin
      state_d = S_IDLE;
    end else begin
      unique case (state_q)
        S_IDLE: if (tick_i) begin
          state_d = S_ADDR;
          ch_d    = '0;
          start_o = 1'b1;
        end
        S_ADDR: begin
          if (chan_on_i[ch_q]) state_d = S_DATA;
          else if (last)       state_d = S_DONE;
          else                 ch_d    = ch_q + 1'b1;
        end
        S_DATA: begin
          if (rdata_i == END_MARK) begin
            reload_o   = 1'b1;
            mem_addr_o = cur_loop_i;
            state_d    = S_LOOP;
          end else begin
            adv_o = 1'b1;
            lat_o = 1'b1;
            if (last) state_d = S_DONE;
            else begin
              ch_d    = ch_q + 1'b1;
              state_d = S_ADDR;
            end
          end
        end
        S_LOOP: begin
          lat_o = 1'b1;
          if (last) state_d = S_DONE;
          else begin
            ch_d    = ch_q + 1'b1;
            state_d = S_ADDR;
          end
        end
        S_DONE:  state_d = S_IDLE;
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ch_q    <= '0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
    end
  end

  // R3: a marker always leads to the refetch step
  p_marker_refetch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == S_DATA && rdata_i == END_MARK) |=> (state_q == S_LOOP));

  // R9: a running sweep never restarts from channel 0
  p_no_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q != S_IDLE) |=> (state_q == S_IDLE || ch_q >= $past(ch_q)));
endmodule

// File: rtl/pcm_mix_ptr.sv
module pcm_mix_ptr #(
  parameter int NCH = 8,
  parameter int AW  = 16,
  parameter int FW  = 11,
  parameter int SW  = 8,
  localparam int PW = AW + FW,
  localparam int CW = $clog2(NCH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic [NCH-1:0]           chan_on_i,
  input  logic [NCH-1:0][SW-1:0]   start_i,
  input  logic [NCH-1:0][AW-1:0]   loop_i,
  input  logic [NCH-1:0][15:0]     step_i,
  input  logic [CW-1:0]            sel_i,
  input  logic                     adv_i,
  input  logic                     reload_i,
  output logic [NCH-1:0][PW-1:0]   ptr_o
);
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic hit;
    assign hit = (sel_i == CW'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               ptr_o[k] <= '0;
      else if (!chan_on_i[k])    ptr_o[k] <= {start_i[k], {(PW-SW){1'b0}}};
      else if (hit && reload_i)  ptr_o[k] <= {loop_i[k], {FW{1'b0}}};
      else if (hit && adv_i)     ptr_o[k] <= ptr_o[k] + PW'(step_i[k]);
    end

    // R1: an inactive channel sits at its start page
    p_off_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !chan_on_i[k] |=> (ptr_o[k] == {$past(start_i[k]), {(PW-SW){1'b0}}}));

    // R8: active pointers freeze while disabled
    p_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i && chan_on_i[k]) |=> (ptr_o[k] == $past(ptr_o[k])));
  end
endmodule

// File: rtl/pcm_mix_mac.sv
module pcm_mix_mac
  import pcm_mix_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW    = $clog2(NCH),
  localparam int ACC_W = 21 + $clog2(NCH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   start_i,
  input  logic                   lat_i,
  input  logic [CW-1:0]          ch_i,
  input  logic [7:0]             byte_i,
  input  logic [NCH-1:0][7:0]    env_i,
  input  logic [NCH-1:0][7:0]    pan_i,
  input  logic                   done_i,
  output logic signed [15:0]     left_o,
  output logic signed [15:0]     right_o,
  output logic                   valid_o
);
  localparam logic signed [ACC_W-1:0] MAXV = 32767;
  localparam logic signed [ACC_W-1:0] MINV = -32768;

  logic [7:0]    smp_q;
  logic          vld_q;
  logic [CW-1:0] ch_q;
  logic [14:0]   me;
  logic [18:0]   pl, pr;
  logic signed [ACC_W-1:0] sl, sr, cl, cr, acc_l, acc_r, nxt_l, nxt_r;

  function automatic logic signed [15:0] sat16(input logic signed [ACC_W-1:0] v);
    if (v > MAXV)      return 16'h7fff;
    else if (v < MINV) return 16'h8000;
    else               return v[15:0];
  endfunction

  // shared magnitude x envelope, then per-side pan nibble
  always_comb begin
    me = {8'b0, smp_q[6:0]} * {7'b0, env_i[ch_q]};
    pl = {4'b0, me} * {15'b0, pan_i[ch_q][3:0]};
    pr = {4'b0, me} * {15'b0, pan_i[ch_q][7:4]};
    sl = $signed(ACC_W'(pl));
    sr = $signed(ACC_W'(pr));
    cl = smp_q[7] ? (sl >>> 5) : ((-sl) >>> 5);
    cr = smp_q[7] ? (sr >>> 5) : ((-sr) >>> 5);
    nxt_l = acc_l + (vld_q ? cl : '0);
    nxt_r = acc_r + (vld_q ? cr : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= '0;
      vld_q <= 1'b0;
      ch_q  <= '0;
      acc_l <= '0;
      acc_r <= '0;
    end else begin
      smp_q <= byte_i;
      vld_q <= lat_i && (byte_i != END_MARK);
      ch_q  <= ch_i;
      if (start_i) begin
        acc_l <= '0;
        acc_r <= '0;
      end else begin
        acc_l <= nxt_l;
        acc_r <= nxt_r;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= done_i && en_i;
      if (!en_i) begin
        left_o  <= '0;
        right_o <= '0;
      end else if (done_i) begin
        left_o  <= sat16(nxt_l);
        right_o <= sat16(nxt_r);
      end
    end
  end

  // R9: valid is a single-cycle pulse
  p_valid_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/pcm_voice_mixer.sv
module pcm_voice_mixer #(
  parameter int NCH = 8,
  parameter int AW  = 16,
  parameter int FW  = 11,
  localparam int PW = AW + FW,
  localparam int CW = $clog2(NCH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sample_tick_i,
  input  logic                   mix_en_i,
  input  logic [NCH-1:0]         chan_on_i,
  input  logic [NCH-1:0][7:0]    env_i,
  input  logic [NCH-1:0][7:0]    pan_i,
  input  logic [NCH-1:0][15:0]   step_i,
  input  logic [NCH-1:0][AW-1:0] loop_i,
  input  logic [NCH-1:0][7:0]    start_i,
  output logic [AW-1:0]          mem_addr_o,
  input  logic [7:0]             mem_rdata_i,
  output logic signed [15:0]     left_o,
  output logic signed [15:0]     right_o,
  output logic                   valid_o
);
  logic [CW-1:0] ch;
  logic adv, reload, lat, start, done;
  logic [NCH-1:0][PW-1:0] ptr;
  logic [AW-1:0] cur_addr;

  assign cur_addr = ptr[ch][PW-1:FW];

  pcm_mix_seq #(.NCH(NCH), .AW(AW)) u_seq (
    .clk_i, .rst_ni,
    .tick_i     (sample_tick_i),
    .en_i       (mix_en_i),
    .chan_on_i,
    .rdata_i    (mem_rdata_i),
    .cur_addr_i (cur_addr),
    .cur_loop_i (loop_i[ch]),
    .ch_o       (ch),
    .mem_addr_o,
    .adv_o      (adv),
    .reload_o   (reload),
    .lat_o      (lat),
    .start_o    (start),
    .done_o     (done)
  );

  pcm_mix_ptr #(.NCH(NCH), .AW(AW), .FW(FW), .SW(8)) u_ptr (
    .clk_i, .rst_ni,
    .en_i      (mix_en_i),
    .chan_on_i,
    .start_i,
    .loop_i,
    .step_i,
    .sel_i     (ch),
    .adv_i     (adv),
    .reload_i  (reload),
    .ptr_o     (ptr)
  );

  pcm_mix_mac #(.NCH(NCH)) u_mac (
    .clk_i, .rst_ni,
    .en_i    (mix_en_i),
    .start_i (start),
    .lat_i   (lat),
    .ch_i    (ch),
    .byte_i  (mem_rdata_i),
    .env_i,
    .pan_i,
    .done_i  (done),
    .left_o,
    .right_o,
    .valid_o
  );

  // R8: disabled mixer is silent on the next cycle
  p_disabled_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mix_en_i |=> (left_o == 16'sd0 && right_o == 16'sd0 && !valid_o));
endmodule

// File: tb/pcm_voice_mixer_tb.sv
module pcm_voice_mixer_tb;
  localparam int NCH = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tick, en;
  logic [NCH-1:0] on;
  logic [NCH-1:0][7:0]  env, pan, st;
  logic [NCH-1:0][15:0] stp, lp;
  logic [15:0] maddr;
  logic [7:0]  mdata;
  logic signed [15:0] lo, ro;
  logic vo;

  logic [7:0] wmem [0:4095];
  logic [26:0] rptr [NCH];
  int n_chk = 0, n_bad = 0;
  int exp_l, exp_r;

  always_ff @(posedge clk) mdata <= wmem[maddr[11:0]];

  pcm_voice_mixer #(.NCH(NCH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_tick_i(tick), .mix_en_i(en),
    .chan_on_i(on), .env_i(env), .pan_i(pan), .step_i(stp), .loop_i(lp),
    .start_i(st), .mem_addr_o(maddr), .mem_rdata_i(mdata),
    .left_o(lo), .right_o(ro), .valid_o(vo)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // independent model of one sample period (memory aliased to 4K like the bench RAM)
  task automatic ref_step();
    int l = 0, r = 0;
    for (int c = 0; c < NCH; c++) begin
      logic [7:0] b;
      int p, q;
      if (on[c]) begin
        b = wmem[rptr[c][22:11]];
        if (b == 8'hFF) begin
          rptr[c] = {lp[c], 11'b0};
          b = wmem[lp[c][11:0]];
        end else begin
          rptr[c] = rptr[c] + {11'b0, stp[c]};
        end
        if (b != 8'hFF) begin
          p = int'(b[6:0]) * int'(env[c]) * int'(pan[c][3:0]);
          q = int'(b[6:0]) * int'(env[c]) * int'(pan[c][7:4]);
          if (!b[7]) begin p = -p; q = -q; end
          l += p >>> 5;
          r += q >>> 5;
        end
      end
    end
    exp_l = (l > 32767) ? 32767 : (l < -32768) ? -32768 : l;
    exp_r = (r > 32767) ? 32767 : (r < -32768) ? -32768 : r;
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wait_valid(string tag);
    int n = 0;
    while (!vo && n < 200) begin
      @(negedge clk);
      n++;
    end
    if (!vo) chk({tag, " valid timeout"}, 0, 1);
  endtask

  task automatic sweep(string tag);
    ref_step();
    pulse_tick();
    wait_valid(tag);
    chk({tag, " left"}, int'(lo), exp_l);
    chk({tag, " right"}, int'(ro), exp_r);
    @(negedge clk);
  endtask

  task automatic set_mask(logic [NCH-1:0] m);
    for (int c = 0; c < NCH; c++) if (!m[c]) rptr[c] = {st[c], 19'b0};
    on = m;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_start(int c, logic [7:0] v);
    st[c] = v;
    if (!on[c]) rptr[c] = {v, 19'b0};
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 left after reset", int'(lo), 0);
    chk("R11 right after reset", int'(ro), 0);
    chk("R11 valid after reset", int'(vo), 0);
  endtask

  task automatic t_single();
    env[0] = 8'h40; pan[0] = 8'h3A; stp[0] = 16'h0C00;
    set_start(0, 8'h01);
    set_mask(8'h01);
    for (int i = 0; i < 6; i++) sweep("R2 R5 single channel");
  endtask

  task automatic t_round();
    set_mask(8'h00);
    for (int i = 0; i < 8; i++) wmem[12'h200 + i] = 8'h01;
    env[0] = 8'h01; pan[0] = 8'h11; stp[0] = 16'h0800;
    set_start(0, 8'h02);
    set_mask(8'h01);
    sweep("R6 negative floor");
    chk("R6 floor value", int'(lo), -1);
  endtask

  task automatic t_mask();
    env[1] = 8'hFF; pan[1] = 8'hFF; stp[1] = 16'h0800;
    set_start(1, 8'h03);
    env[0] = 8'h20; pan[0] = 8'h55;
    set_start(0, 8'h01);
    sweep("R1 masked channel silent");
    set_mask(8'h03);
    for (int i = 0; i < 3; i++) sweep("R1 channel from start page");
  endtask

  task automatic t_loop();
    set_mask(8'h00);
    wmem[12'h500] = 8'h90; wmem[12'h501] = 8'h85; wmem[12'h502] = 8'hFF;
    env[2] = 8'h80; pan[2] = 8'h7C; stp[2] = 16'h0800; lp[2] = 16'h0500;
    set_start(2, 8'h05);
    set_mask(8'h04);
    for (int i = 0; i < 7; i++) sweep("R3 loop reload");
  endtask

  task automatic t_silent();
    set_mask(8'h00);
    wmem[12'h600] = 8'hC0; wmem[12'h601] = 8'hFF; wmem[12'h610] = 8'hFF;
    env[3] = 8'hFF; pan[3] = 8'hFF; stp[3] = 16'h0800; lp[3] = 16'h0610;
    set_start(3, 8'h06);
    set_mask(8'h08);
    sweep("R4 first sample audible");
    sweep("R4 double marker");
    chk("R4 silent left", int'(lo), 0);
    sweep("R4 stays silent");
    chk("R4 silent right", int'(ro), 0);
  endtask

  task automatic t_clamp();
    set_mask(8'h00);
    for (int i = 0; i < 64; i++) begin
      wmem[12'hE00 + i] = 8'hFE;
      wmem[12'hD00 + i] = 8'h7F;
    end
    for (int c = 0; c < NCH; c++) begin
      env[c] = 8'hFF; pan[c] = 8'hFF; stp[c] = 16'h0800; st[c] = 8'h0E;
    end
    set_mask(8'h00);
    set_mask(8'hFF);
    sweep("R7 positive clamp");
    chk("R7 left max", int'(lo), 32767);
    set_mask(8'h00);
    for (int c = 0; c < NCH; c++) st[c] = 8'h0D;
    set_mask(8'h00);
    set_mask(8'hFF);
    sweep("R7 negative clamp");
    chk("R7 right min", int'(ro), -32768);
  endtask

  task automatic t_disable();
    int seen = 0;
    set_mask(8'h00);
    for (int c = 0; c < NCH; c++) st[c] = 8'h01;
    set_mask(8'h00);
    env[0] = 8'h70; pan[0] = 8'hA5;
    set_mask(8'h01);
    sweep("R8 before disable");
    en = 1'b0;
    @(negedge clk);
    chk("R8 left zero", int'(lo), 0);
    chk("R8 right zero", int'(ro), 0);
    pulse_tick();
    for (int i = 0; i < 60; i++) begin
      if (vo) seen++;
      @(negedge clk);
    end
    chk("R8 no valid while off", seen, 0);
    en = 1'b1;
    @(negedge clk);
    sweep("R8 pointer frozen");
  endtask

  task automatic t_midtick();
    int seen = 0;
    for (int c = 1; c < 4; c++) begin
      env[c] = 8'h30; pan[c] = 8'h9F; stp[c] = 16'h0A00;
    end
    set_mask(8'h0F);
    ref_step();
    pulse_tick();
    @(negedge clk);
    @(negedge clk);
    pulse_tick();
    wait_valid("R9 mid tick");
    chk("R9 left", int'(lo), exp_l);
    chk("R9 right", int'(ro), exp_r);
    @(negedge clk);
    for (int i = 0; i < 60; i++) begin
      if (vo) seen++;
      @(negedge clk);
    end
    chk("R9 one pulse per sweep", seen, 0);
    sweep("R9 next sweep");
  endtask

  task automatic t_wrap();
    set_mask(8'h00);
    env[4] = 8'h90; pan[4] = 8'h6B; stp[4] = 16'hFFFF;
    set_start(4, 8'hFF);
    set_mask(8'h10);
    for (int i = 0; i < 12; i++) sweep("R10 pointer wrap");
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) wmem[i] = 8'((i * 37 + 5) & 8'hFE);
    for (int c = 0; c < NCH; c++) begin
      rptr[c] = '0; env[c] = '0; pan[c] = '0; st[c] = '0; stp[c] = '0; lp[c] = '0;
    end
    rst_n = 1'b0; tick = 1'b0; en = 1'b1; on = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_round();
    t_mask();
    t_loop();
    t_silent();
    t_clamp();
    t_disable();
    t_midtick();
    t_wrap();
    summary();
    $finish;
  end
endmodule